// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It reads a four-level radix page table from memory, one 64-bit entry at a time, starting from a root table base given as a physical address. Every table has 512 entries of 8 bytes, and pages are 4096 bytes. At each level the walker checks the permission flags in the entry against the access type of the request. A walk ends early on the first entry that is missing or forbids the access.

A client presents a virtual address with a write flag and a user flag. The walker accepts the request only while it is idle. It then issues reads on a simple memory port, where each read is held until the memory signals that data is valid. When the walk ends, the walker returns a one-cycle response. The response carries either the translated physical address or a fault, together with the level and the reason for the fault. Only one walk is in flight at any time.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high exactly while the walker is idle. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. `req_valid`, `req_va` and `root_base` have no effect while a walk is in progress.
- R2: While a read is pending, `mem_req_valid` stays high and `mem_req_addr` stays stable. The entry on `mem_rsp_data` is taken at the first rising edge where `mem_rsp_valid` is high. Only one read is pending at any time, and the memory latency may be any number of cycles.
- R3: The read address is the current table base plus 8 times the 9-bit index for the level. The level-4 index is VA[47:39], level 3 is VA[38:30], level 2 is VA[29:21] and level 1 is VA[20:12]. The first base is `root_base` as sampled when the request is accepted.
- R4: Tables are read in the order level 4, 3, 2, 1. The base of the next table is entry bits [51:12] followed by twelve zero bits.
- R5: A walk with no fault makes exactly four reads. It responds with `rsp_fault`=0, `rsp_cause`=0, `rsp_level`=1 and `rsp_pa` = {leaf entry[51:12], VA[11:0]}. Entry bits [63:52] have no effect.
- R6: An entry whose present bit (bit 0) is clear ends the walk. The response has `rsp_fault`=1, `rsp_cause`=1 and `rsp_level` set to that level, and no further reads are made.
- R7: A write request faults with `rsp_cause`=2 at the first level whose entry has the writable bit (bit 1) clear. A read request ignores that bit.
- R8: A user request faults with `rsp_cause`=3 at the first level whose entry has the user bit (bit 2) clear. A supervisor request ignores that bit.
- R9: When one entry breaks more than one rule, the reported cause follows this priority: not-present, then write-protect, then user-protect.
- R10: `rsp_valid` is a one-cycle pulse in the cycle after the edge that takes the final entry. In that same cycle the walker is idle, so `req_ready` is high and `mem_req_valid` is low.
- R11: After reset, `req_ready`=1, `mem_req_valid`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 52 | Physical base address of the level-4 table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 48 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user access, 0 = supervisor access |
| mem_req_valid | output | 1 | Entry read pending |
| mem_req_addr | output | 52 | Physical address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid; the read completes at this edge |
| mem_rsp_data | input | 64 | Page table entry read from memory |
| rsp_valid | output | 1 | One-cycle pulse when the walk ends |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_level | output | 3 | Level (4 down to 1) at which the walk ended |
| rsp_cause | output | 2 | 0 none, 1 not-present, 2 write-protect, 3 user-protect |
| rsp_pa | output | 52 | Translated physical address (0 on a fault) |

## Verification
The bench chooses distinct indexes for all four levels. A walker that used the wrong VA bit field or a shift other than 3 for the entry size would read the wrong addresses, and the logged read addresses would expose it. Faults are placed at levels 4, 3, 2 and 1, and the bench counts the reads after each one. A walker that kept reading past a fault, or that checked permissions only on the leaf entry, would show an extra read or a missing fault. The bench also sets entries that break several rules at once, to catch a wrong fault priority, and sets high entry bits, to catch a frame mask that is too wide. Finally, it changes `req_va`, `req_valid` and `root_base` during a walk under a long memory latency. A walker that sampled these inputs late or accepted a second request would give a wrong address or respond twice.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_ABSENT  = 2'd1,
    CAUSE_WRPROT  = 2'd2,
    CAUSE_USRPROT = 2'd3
  } walk_cause_e;

  localparam int FLAG_PRESENT  = 0;
  localparam int FLAG_WRITABLE = 1;
  localparam int FLAG_USER     = 2;
  localparam int FLAG_BITS     = 3;

endpackage

// File: rtl/pt_index_sel.sv
module pt_index_sel #(
  parameter int VA_W        = 48,
  parameter int PA_W        = 52,
  parameter int IDX_W       = 9,
  parameter int OFF_W       = 12,
  parameter int LVL_W       = 3,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] level,
  input  logic [PA_W-1:0]  table_base,
  output logic [PA_W-1:0]  entry_addr
);

  // The index field for level L starts at OFF_W + (L-1)*IDX_W.
  function automatic logic [IDX_W-1:0] table_index(input logic [VA_W-1:0] v,
                                                   input logic [LVL_W-1:0] lvl);
    int base_bit;
    base_bit = OFF_W + (int'(lvl) - 1) * IDX_W;
    return IDX_W'(v >> base_bit);
  endfunction

  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] tb,
                                                input logic [IDX_W-1:0] idx);
    return tb + (PA_W'(idx) << ENTRY_SHIFT);
  endfunction

  assign entry_addr = slot_addr(table_base, table_index(va, level));

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
  import pt_walker_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int PA_W    = 52,
  parameter int OFF_W   = 12
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic               is_write,
  input  logic               is_user,
  output logic [1:0]         fault_cause,
  output logic [PA_W-1:0]    next_base
);

  logic unused_entry_bits;

  function automatic logic [PA_W-1:0] frame_base(input logic [ENTRY_W-1:0] e);
    return {e[PA_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic walk_cause_e judge(input logic [ENTRY_W-1:0] e,
                                        input logic wr, input logic usr);
    if (!e[FLAG_PRESENT])             return CAUSE_ABSENT;
    else if (wr && !e[FLAG_WRITABLE]) return CAUSE_WRPROT;
    else if (usr && !e[FLAG_USER])    return CAUSE_USRPROT;
    else                              return CAUSE_NONE;
  endfunction

  assign next_base         = frame_base(entry);
  assign fault_cause       = judge(entry, is_write, is_user);
  assign unused_entry_bits = ^{entry[ENTRY_W-1:PA_W], entry[OFF_W-1:FLAG_BITS]};

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  parameter int LVL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_user,
  input  logic [PA_W-1:0]  root_base,
  output logic             req_ready,
  input  logic             mem_rsp_valid,
  output logic             mem_req_valid,
  input  logic [1:0]       fault_cause,
  input  logic [PA_W-1:0]  next_base,
  output logic [VA_W-1:0]  cur_va,
  output logic             cur_write,
  output logic             cur_user,
  output logic [PA_W-1:0]  cur_base,
  output logic [LVL_W-1:0] cur_level,
  output logic             entry_take,
  output logic             walk_end,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [LVL_W-1:0] rsp_level,
  output logic [1:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_pa
);

  typedef enum logic {ST_IDLE, ST_FETCH} walk_state_e;
  walk_state_e state;
  logic        fault_now;

  function automatic logic [PA_W-1:0] join_pa(input logic [PA_W-1:0] frame,
                                              input logic [VA_W-1:0] v);
    return frame | {{(PA_W-OFF_W){1'b0}}, v[OFF_W-1:0]};
  endfunction

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_FETCH);
  assign entry_take    = (state == ST_FETCH) && mem_rsp_valid;
  assign fault_now     = (fault_cause != CAUSE_NONE);
  assign walk_end      = fault_now || (cur_level == LVL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_va    <= '0;
      cur_write <= 1'b0;
      cur_user  <= 1'b0;
      cur_base  <= '0;
      cur_level <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_level <= '0;
      rsp_cause <= '0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_va    <= req_va;
            cur_write <= req_write;
            cur_user  <= req_user;
            cur_base  <= root_base;
            cur_level <= LVL_W'(LEVELS);
            state     <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_rsp_valid) begin
            if (walk_end) begin
              state     <= ST_IDLE;
              rsp_valid <= 1'b1;
              rsp_fault <= fault_now;
              rsp_level <= cur_level;
              rsp_cause <= fault_cause;
              rsp_pa    <= fault_now ? '0 : join_pa(next_base, cur_va);
            end else begin
              cur_base  <= next_base;
              cur_level <= cur_level - LVL_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 52,
  parameter int ENTRY_W = 64,
  parameter int LEVELS  = 4,
  parameter int IDX_W   = 9,
  parameter int OFF_W   = 12,
  localparam int LVL_W       = $clog2(LEVELS + 1),
  localparam int ENTRY_SHIFT = $clog2(ENTRY_W / 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PA_W-1:0]    root_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_write,
  input  logic               req_user,
  output logic               mem_req_valid,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [LVL_W-1:0]   rsp_level,
  output logic [1:0]         rsp_cause,
  output logic [PA_W-1:0]    rsp_pa
);

  logic [VA_W-1:0]  cur_va;
  logic             cur_write;
  logic             cur_user;
  logic [PA_W-1:0]  cur_base;
  logic [LVL_W-1:0] cur_level;
  logic             entry_take;
  logic             walk_end;
  logic [1:0]       fault_cause;
  logic [PA_W-1:0]  next_base;

  pt_index_sel #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .LVL_W(LVL_W), .ENTRY_SHIFT(ENTRY_SHIFT)
  ) i_index_sel (
    .va         (cur_va),
    .level      (cur_level),
    .table_base (cur_base),
    .entry_addr (mem_req_addr)
  );

  pt_entry_eval #(
    .ENTRY_W(ENTRY_W), .PA_W(PA_W), .OFF_W(OFF_W)
  ) i_entry_eval (
    .entry       (mem_rsp_data),
    .is_write    (cur_write),
    .is_user     (cur_user),
    .fault_cause (fault_cause),
    .next_base   (next_base)
  );

  pt_walk_fsm #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) i_walk_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_va        (req_va),
    .req_write     (req_write),
    .req_user      (req_user),
    .root_base     (root_base),
    .req_ready     (req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .fault_cause   (fault_cause),
    .next_base     (next_base),
    .cur_va        (cur_va),
    .cur_write     (cur_write),
    .cur_user      (cur_user),
    .cur_base      (cur_base),
    .cur_level     (cur_level),
    .entry_take    (entry_take),
    .walk_end      (walk_end),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_level     (rsp_level),
    .rsp_cause     (rsp_cause),
    .rsp_pa        (rsp_pa)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W  = 52,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [LVL_W-1:0] rsp_level,
  input logic [1:0]       rsp_cause,
  input logic             entry_take,
  input logic             walk_end,
  input logic [LVL_W-1:0] cur_level
);

  // R1: no read is pending while the walker reports itself idle
  a_r1_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  // R2: a pending read keeps its address until data arrives
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4: a non-final entry moves the walk down exactly one level
  a_r4_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_take && !walk_end) |=> (cur_level == ($past(cur_level) - LVL_W'(1))));

  // R5: a walk without fault always ends at level 1
  a_r5_success_level1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_level == LVL_W'(1) && rsp_cause == 2'd0));

  // R6: a fault always carries a reason and a level from 1 to 4
  a_r6_fault_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_cause != 2'd0 && rsp_level != '0 && rsp_level <= LVL_W'(4)));

  // R10: the response follows an entry being taken, lasts one cycle, and finds the walker idle
  a_r10_rsp_from_take: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(entry_take));
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r10_idle_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && !mem_req_valid));

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .LVL_W(LVL_W)) i_chk (.*);

// File: tb/test_pt_walker.sv
module test_pt_walker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:0] root_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        mem_req_valid;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [2:0]  rsp_level;
  logic [1:0]  rsp_cause;
  logic [51:0] rsp_pa;

  pt_walker i_pt_walker (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // memory model
  logic [63:0] mem [logic [51:0]];
  int          lat = 0;
  int          wait_cnt = 0;
  int          reads = 0;
  logic [51:0] rd_addr [0:7];

  // response monitor
  logic        got_rsp = 1'b0;
  logic        got_fault;
  logic [2:0]  got_level;
  logic [1:0]  got_cause;
  logic [51:0] got_pa;
  logic        got_ready;
  int          rsp_cnt = 0;

  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) begin
        mem_rsp_valid = 1'b0;
      end else if (mem_req_valid) begin
        if (wait_cnt < lat) begin
          wait_cnt++;
        end else begin
          wait_cnt = 0;
          mem_rsp_data  = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
          mem_rsp_valid = 1'b1;
          if (reads < 8) rd_addr[reads] = mem_req_addr;
          reads++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rsp_valid) begin
      got_rsp   = 1'b1;
      got_fault = rsp_fault;
      got_level = rsp_level;
      got_cause = rsp_cause;
      got_pa    = rsp_pa;
      got_ready = req_ready && !mem_req_valid;
      rsp_cnt++;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [8:0] vidx(input logic [47:0] va, input int lvl);
    return va[12 + 9*(lvl-1) +: 9];
  endfunction

  function automatic logic [47:0] mk_va(input int i4, input int i3, input int i2,
                                        input int i1, input int off);
    return (48'(i4) << 39) | (48'(i3) << 30) | (48'(i2) << 21) |
           (48'(i1) << 12) | 48'(off & 12'hfff);
  endfunction

  // tables of a walk sit at root, root+0x1000, root+0x2000, root+0x3000
  function automatic logic [51:0] tab(input logic [51:0] root, input int lvl);
    return root + 52'((4 - lvl) * 4096);
  endfunction

  task automatic build(input logic [51:0] root, input logic [47:0] va,
                       input logic [51:0] frame, input logic [2:0] f4,
                       input logic [2:0] f3, input logic [2:0] f2,
                       input logic [2:0] f1, input logic [11:0] hi);
    mem[tab(root,4) + 52'(vidx(va,4))*8] = {hi, tab(root,3)} | 64'(f4);
    mem[tab(root,3) + 52'(vidx(va,3))*8] = {hi, tab(root,2)} | 64'(f3);
    mem[tab(root,2) + 52'(vidx(va,2))*8] = {hi, tab(root,1)} | 64'(f2);
    mem[tab(root,1) + 52'(vidx(va,1))*8] = {hi, frame}       | 64'(f1);
  endtask

  task automatic start_walk(input logic [51:0] root, input logic [47:0] va,
                            input logic wr, input logic usr);
    while (!req_ready) @(negedge clk);
    reads = 0; got_rsp = 1'b0; rsp_cnt = 0;
    root_base = root; req_va = va; req_write = wr; req_user = usr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input string req);
    int n = 0;
    while (!got_rsp && n < 400) begin @(negedge clk); n++; end
    chk(req, "response arrived", 64'(got_rsp), 64'd1);
  endtask

  task automatic run_walk(input string req, input logic [51:0] root,
                          input logic [47:0] va, input logic wr, input logic usr);
    start_walk(root, va, wr, usr);
    wait_rsp(req);
  endtask

  task automatic expect_fault(input string req, input logic [2:0] lvl,
                              input logic [1:0] cause, input int nreads);
    chk(req, "fault", 64'(got_fault), 64'd1);
    chk(req, "level", 64'(got_level), 64'(lvl));
    chk(req, "cause", 64'(got_cause), 64'(cause));
    repeat (4) @(negedge clk);
    chk(req, "reads", 64'(reads), 64'(nreads));
  endtask

  task automatic expect_ok(input string req, input logic [51:0] pa);
    chk(req, "fault", 64'(got_fault), 64'd0);
    chk(req, "cause", 64'(got_cause), 64'd0);
    chk(req, "level", 64'(got_level), 64'd1);
    chk(req, "pa", 64'(got_pa), 64'(pa));
    chk(req, "reads", 64'(reads), 64'd4);
  endtask

  // R11: state after reset
  task automatic t_reset;
    chk("R11", "req_ready", 64'(req_ready), 64'd1);
    chk("R11", "mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk("R11", "rsp_valid", 64'(rsp_valid), 64'd0);
  endtask

  // R3 R4 R5: full walk, read addresses and order
  task automatic t_basic;
    logic [51:0] root = 52'h0_0001_0000;
    logic [47:0] va = mk_va(9'h1a3, 9'h055, 9'h100, 9'h0ff, 12'habc);
    mem.delete(); lat = 0;
    build(root, va, 52'h9_8765_4000, 3'h7, 3'h7, 3'h7, 3'h7, 12'h0);
    run_walk("R5", root, va, 1'b0, 1'b0);
    expect_ok("R5", 52'h9_8765_4abc);
    for (int l = 4; l >= 1; l--)
      chk("R3", $sformatf("read addr level %0d", l), 64'(rd_addr[4-l]),
          64'(tab(root,l) + 52'(vidx(va,l))*8));
  endtask

  // R2: long memory latency gives the same result
  task automatic t_latency;
    logic [51:0] root = 52'h0_0002_0000;
    logic [47:0] va = mk_va(9'h001, 9'h1ff, 9'h0a0, 9'h133, 12'h007);
    mem.delete(); lat = 6;
    build(root, va, 52'h1_2345_6000, 3'h7, 3'h7, 3'h7, 3'h7, 12'h0);
    run_walk("R2", root, va, 1'b1, 1'b1);
    expect_ok("R2", 52'h1_2345_6007);
    chk("R2", "last read addr", 64'(rd_addr[3]), 64'(tab(root,1) + 52'(vidx(va,1))*8));
    lat = 0;
  endtask

  // R5 R4: entry bits 63..52 do not reach the address
  task automatic t_hibits;
    logic [51:0] root = 52'h0_0003_0000;
    logic [47:0] va = mk_va(9'h0f0, 9'h00f, 9'h1e1, 9'h002, 12'hfff);
    mem.delete(); lat = 1;
    build(root, va, 52'hf_ffff_f000, 3'h7, 3'h7, 3'h7, 3'h7, 12'hfff);
    run_walk("R5", root, va, 1'b0, 1'b0);
    expect_ok("R5", 52'hf_ffff_ffff);
    chk("R4", "level-3 read addr", 64'(rd_addr[1]), 64'(tab(root,3) + 52'(vidx(va,3))*8));
    lat = 0;
  endtask

  // R6: not-present at level 4 (empty memory) and at level 2
  task automatic t_absent;
    logic [51:0] root = 52'h0_0004_0000;
    logic [47:0] va = mk_va(9'h011, 9'h022, 9'h033, 9'h044, 12'h123);
    mem.delete();
    run_walk("R6", root, va, 1'b0, 1'b0);
    expect_fault("R6", 3'd4, 2'd1, 1);
    build(root, va, 52'h5_0000_0000, 3'h7, 3'h7, 3'h6, 3'h7, 12'h0);
    run_walk("R6", root, va, 1'b0, 1'b0);
    expect_fault("R6", 3'd2, 2'd1, 3);
  endtask

  // R7: write-protect at level 3; a read ignores the writable bit
  task automatic t_wprot;
    logic [51:0] root = 52'h0_0005_0000;
    logic [47:0] va = mk_va(9'h100, 9'h101, 9'h102, 9'h103, 12'h456);
    mem.delete();
    build(root, va, 52'h7_7777_7000, 3'h7, 3'h5, 3'h7, 3'h7, 12'h0);
    run_walk("R7", root, va, 1'b1, 1'b0);
    expect_fault("R7", 3'd3, 2'd2, 2);
    run_walk("R7", root, va, 1'b0, 1'b1);
    expect_ok("R7", 52'h7_7777_7456);
  endtask

  // R8: user-protect at level 1; a supervisor access ignores the user bit
  task automatic t_uprot;
    logic [51:0] root = 52'h0_0006_0000;
    logic [47:0] va = mk_va(9'h0aa, 9'h155, 9'h0cc, 9'h033, 12'h800);
    mem.delete();
    build(root, va, 52'h3_3333_3000, 3'h7, 3'h7, 3'h7, 3'h3, 12'h0);
    run_walk("R8", root, va, 1'b0, 1'b1);
    expect_fault("R8", 3'd1, 2'd3, 4);
    run_walk("R8", root, va, 1'b1, 1'b0);
    expect_ok("R8", 52'h3_3333_3800);
  endtask

  // R9: cause priority on one entry breaking several rules
  task automatic t_priority;
    logic [51:0] root = 52'h0_0007_0000;
    logic [47:0] va = mk_va(9'h003, 9'h004, 9'h005, 9'h006, 12'h010);
    mem.delete();
    build(root, va, 52'h2_0000_0000, 3'h7, 3'h7, 3'h1, 3'h7, 12'h0);
    run_walk("R9", root, va, 1'b1, 1'b1);
    expect_fault("R9", 3'd2, 2'd2, 3);
    build(root, va, 52'h2_0000_0000, 3'h7, 3'h7, 3'h0, 3'h7, 12'h0);
    run_walk("R9", root, va, 1'b1, 1'b1);
    expect_fault("R9", 3'd2, 2'd1, 3);
  endtask

  // R1 R10: inputs during a walk are ignored; one single-cycle response, walker idle
  task automatic t_busy;
    logic [51:0] root = 52'h0_0008_0000;
    logic [47:0] va = mk_va(9'h1f0, 9'h0e0, 9'h0d0, 9'h0c0, 12'h321);
    mem.delete(); lat = 3;
    build(root, va, 52'h4_4444_4000, 3'h7, 3'h7, 3'h7, 3'h7, 12'h0);
    start_walk(root, va, 1'b0, 1'b0);
    @(negedge clk);
    chk("R1", "req_ready while busy", 64'(req_ready), 64'd0);
    req_va = mk_va(9'h001, 9'h001, 9'h001, 9'h001, 12'h000);
    root_base = 52'h0_00ff_0000;
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_rsp("R1");
    chk("R1", "pa of first request", 64'(got_pa), 64'(52'h4_4444_4321));
    chk("R10", "idle in response cycle", 64'(got_ready), 64'd1);
    chk("R10", "rsp_valid width", 64'(rsp_valid), 64'd0);
    repeat (20) @(negedge clk);
    chk("R1", "responses", 64'(rsp_cnt), 64'd1);
    chk("R1", "reads", 64'(reads), 64'd4);
    lat = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_latency();
    t_hibits();
    t_absent();
    t_wprot();
    t_uprot();
    t_priority();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule